// File: doc/BRIEF.md
# Shift-Left-and-Add Execution Unit

This execution slice of a 32-bit processor carries out two left-shift operations. The first copies a source register value into the destination while shifting it left. The second shifts the old destination value left and then adds a source register value. Each operation takes one cycle. The unit decodes the 16-bit instruction word and takes both register read values from the register file. One clock edge later it presents the result, a write enable, a trap flag and the condition codes held in a register.

The shift count comes from a 4-bit field. A field value from 1 to 15 gives that many positions, and a field value of zero gives a shift of 16. Register zero is illegal in one role for each operation. The move form traps when the source field is zero. The add form traps when the destination field is zero. The move form with destination zero is legal: it updates the condition codes and writes nothing, so it can serve as a bit test. The add form reads a zero source field as the constant zero, which turns it into a plain left shift of the destination.

Top module: `shl_add_unit`

## Requirements
- R1: The shift amount is field instr[3:0] in plain binary for values 1 to 15, and the value 0 means a shift of 16 positions.
- R2: An instruction is accepted on a clock edge where in_valid is high. Fields: instr[15:12] is the opcode, instr[11:8] the destination index, instr[7:4] the source index. Opcode 4'b1011 (move-shift) puts src_val shifted left by the amount on result one edge later, with wr_en high for that one cycle.
- R3: Opcode 4'b1010 (shift-add) puts (dst_val shifted left by the amount) + src_val, modulo 2^32, on result one edge later, with wr_en high.
- R4: For shift-add with source index 0, src_val is ignored and the constant zero is added, so the result is dst_val shifted left.
- R5: C is set when any one bit is lost off bit 31 by the shift, or when the following add carries out of bit 31.
- R6: V is set when the shifted value read as signed differs from the operand times 2^amount, or when the signed 32-bit add overflows.
- R7: N equals bit 31 of the result and Z is set when the result is zero. The flags are presented as flags = {N, Z, V, C}.
- R8: Move-shift with source index 0 raises trap for one cycle, keeps wr_en low, and leaves flags and result unchanged.
- R9: Shift-add with destination index 0 raises trap for one cycle, keeps wr_en low, and leaves flags and result unchanged.
- R10: Move-shift with destination index 0 and a nonzero source index updates result and flags, keeps wr_en low, and raises no trap.
- R11: A cycle with in_valid low, or with any other opcode, produces no write and no trap, and leaves flags and result unchanged.
- R12: After a synchronous active-low reset, result, wr_en, trap and flags are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 16 | Instruction word |
| dst_val | input | 32 | Register read value selected by the destination field |
| src_val | input | 32 | Register read value selected by the source field |
| result | output | 32 | Computed value, held until the next legal operation |
| wr_en | output | 1 | Write the result to the destination register |
| trap | output | 1 | Illegal-instruction trap pulse |
| flags | output | 4 | Condition codes {N, Z, V, C} |

## Verification
Any wrong state in the unit appears at the ports one edge after the instruction that caused it. A misdecoded count or operand select gives a wrong result or carry in that cycle. A flag register that was updated wrongly, or not held, stays visibly wrong through every later idle or trapping cycle until the next legal operation overwrites it. For this reason the bench checks result and flags on every cycle, including cycles that should change nothing. It covers every count encoding with operands chosen to land on the lost-bit, carry and sign boundaries.

// File: rtl/shl_add_pkg.sv
// Package: shared constants and types for the shift-left-and-add unit.
// Assumes the opcode sits in the top nibble of the instruction word.
package shl_add_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 4;
    localparam int IDX_W  = 4;

    localparam logic [3:0] OPC_MOVSHL = 4'b1011;
    localparam logic [3:0] OPC_SHLADD = 4'b1010;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;
endpackage

// File: rtl/shl_add_decode.sv
// Module: instruction decoder. Splits the word into fields, expands the
// count (zero means 2**CNT_W) and classifies legality. Purely combinational.
// Assumes opcode in instr[15:12], dst [11:8], src [7:4], count [3:0].
module shl_add_decode
    import shl_add_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int IW = IDX_W
) (
    input  logic [15:0]   instr,
    input  logic          in_valid,
    output logic          is_mov,
    output logic          is_add,
    output logic [IW-1:0] dst_idx,
    output logic [IW-1:0] src_idx,
    output logic [CW:0]   shamt,
    output logic          do_trap,
    output logic          do_update,
    output logic          do_write
);
    logic [CW-1:0] cnt_field;

    // Field extraction and count expansion.
    always_comb begin
        dst_idx   = instr[11:8];
        src_idx   = instr[7:4];
        cnt_field = instr[CW-1:0];
        shamt     = (cnt_field == '0) ? (CW+1)'(1 << CW) : {1'b0, cnt_field};
    end

    // Opcode classification and legality of register-zero roles.
    always_comb begin
        is_mov    = in_valid && (instr[15:12] == OPC_MOVSHL);
        is_add    = in_valid && (instr[15:12] == OPC_SHLADD);
        do_trap   = (is_mov && (src_idx == '0)) || (is_add && (dst_idx == '0));
        do_update = (is_mov || is_add) && !do_trap;
        do_write  = do_update && (dst_idx != '0);
    end
endmodule

// File: rtl/shl_add_shifter.sv
// Module: left shifter with lost-bit and signed-overflow detection.
// Assumes 1 <= shamt <= W-1; bits shifted past the top are reported, not kept.
module shl_add_shifter #(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [W-1:0]  x,
    input  logic [SW-1:0] shamt,
    output logic [W-1:0]  y,
    output logic          lost_ones,
    output logic          sign_ovf
);
    localparam int WIDE = 2 * W;

    logic [WIDE-1:0] wide;
    logic [W-1:0]    in_win;
    logic [W-1:0]    differs;

    // Double-width shift keeps the bits that fall off the top.
    always_comb begin
        wide      = {{W{1'b0}}, x} << shamt;
        y         = wide[W-1:0];
        lost_ones = |wide[WIDE-1:W];
    end

    // Bits from W-1-shamt upward must all match the sign for a clean signed shift.
    for (genvar g = 0; g < W; g++) begin : g_win
        assign in_win[g]  = (32'(shamt) >= 32'(W - 1 - g));
        assign differs[g] = in_win[g] && (x[g] != x[W-1]);
    end

    // Signed overflow whenever any window bit disagrees with the sign.
    always_comb sign_ovf = |differs;
endmodule

// File: rtl/shl_add_adder.sv
// Module: W-bit adder reporting unsigned carry out and signed overflow.
// Assumes two's complement operands.
module shl_add_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] full;

    // Sum with carry, then signed overflow from the operand and result signs.
    always_comb begin
        full = {1'b0, a} + {1'b0, b};
        sum  = full[W-1:0];
        cout = full[W];
        ovf  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/shl_add_unit.sv
// Module: top of the shift-left-and-add execution slice. One registered
// stage: decode, shift, add and flag generation happen in the cycle the
// instruction is valid, and results appear after the next rising edge.
// Assumes the register file supplies both read values in the same cycle.
module shl_add_unit
    import shl_add_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [15:0]        instr,
    input  logic [DATA_W-1:0]  dst_val,
    input  logic [DATA_W-1:0]  src_val,
    output logic [DATA_W-1:0]  result,
    output logic               wr_en,
    output logic               trap,
    output logic [3:0]         flags
);
    localparam int SW = CNT_W + 1;

    logic              is_mov, is_add, do_trap, do_update, do_write;
    logic [IDX_W-1:0]  dst_idx, src_idx;
    logic [SW-1:0]     shamt;
    logic [DATA_W-1:0] shl_in, shl_out, addend, sum;
    logic              lost_ones, sign_ovf, cout, add_ovf;
    cc_t               cc_next, cc_q;
    logic [DATA_W-1:0] res_q;
    logic              wr_q, trap_q;

    shl_add_decode #(.CW(CNT_W), .IW(IDX_W)) u_dec (
        .instr     (instr),
        .in_valid  (in_valid),
        .is_mov    (is_mov),
        .is_add    (is_add),
        .dst_idx   (dst_idx),
        .src_idx   (src_idx),
        .shamt     (shamt),
        .do_trap   (do_trap),
        .do_update (do_update),
        .do_write  (do_write)
    );

    // Operand select: move shifts the source, shift-add shifts the destination.
    always_comb begin
        shl_in = is_mov ? src_val : dst_val;
        addend = (is_add && (src_idx != '0)) ? src_val : '0;
    end

    shl_add_shifter #(.W(DATA_W), .SW(SW)) u_shl (
        .x         (shl_in),
        .shamt     (shamt),
        .y         (shl_out),
        .lost_ones (lost_ones),
        .sign_ovf  (sign_ovf)
    );

    shl_add_adder #(.W(DATA_W)) u_add (
        .a    (shl_out),
        .b    (addend),
        .sum  (sum),
        .cout (cout),
        .ovf  (add_ovf)
    );

    // Condition codes from the final sum and both stages' exception bits.
    always_comb begin
        cc_next.n = sum[DATA_W-1];
        cc_next.z = (sum == '0);
        cc_next.v = sign_ovf || add_ovf;
        cc_next.c = lost_ones || cout;
    end

    // Output stage: pulses for write/trap, held state for result and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            cc_q   <= '0;
            wr_q   <= 1'b0;
            trap_q <= 1'b0;
        end else begin
            wr_q   <= do_write;
            trap_q <= do_trap;
            if (do_update) begin
                res_q <= sum;
                cc_q  <= cc_next;
            end
        end
    end

    assign result = res_q;
    assign wr_en  = wr_q;
    assign trap   = trap_q;
    assign flags  = cc_q;

    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> !wr_q); // R8
    AST_TRAP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> ($stable(cc_q) && $stable(res_q))); // R9
    AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> $past(in_valid)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!wr_q && !trap_q && $stable(cc_q))); // R11
    AST_N_IS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> (cc_q.n == res_q[DATA_W-1])); // R7
    AST_Z_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> (cc_q.z == (res_q == '0))); // R7
endmodule

// File: tb/shl_add_unit_test.sv
`timescale 1ns/1ps
module shl_add_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] dst_val = '0;
    logic [31:0] src_val = '0;
    logic [31:0] result;
    logic        wr_en, trap;
    logic [3:0]  flags;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        logic [31:0] res;
        logic        wr;
        logic        trp;
        logic [3:0]  cc;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] m_res = '0;
    logic [3:0]  m_cc  = '0;
    logic [31:0] lfsr  = 32'hACE1_2468;

    always #4 clk = ~clk; // 125 MHz

    shl_add_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .dst_val(dst_val), .src_val(src_val), .result(result),
        .wr_en(wr_en), .trap(trap), .flags(flags)
    );

    // Reference model written straight from the requirements.
    function automatic exp_t model(logic v, logic [15:0] ins, logic [31:0] dv,
                                   logic [31:0] sv, string req);
        exp_t e;
        logic [3:0] opc, d, s1;
        int s;
        logic mov, add;
        logic [31:0] x, b, sh;
        logic [63:0] wide, usum;
        logic signed [63:0] prod, ssum;
        logic lost, sovf, aovf;
        opc = ins[15:12]; d = ins[11:8]; s1 = ins[7:4];
        s = (ins[3:0] == 4'd0) ? 16 : int'(ins[3:0]); // R1
        mov = v && (opc == 4'b1011);
        add = v && (opc == 4'b1010);
        e.req = req; e.wr = 1'b0; e.trp = 1'b0;
        if ((mov && s1 == 4'd0) || (add && d == 4'd0)) begin
            e.trp = 1'b1;
        end else if (mov || add) begin
            x    = mov ? sv : dv;
            b    = (add && s1 != 4'd0) ? sv : 32'd0;
            wide = {32'd0, x} << s;
            sh   = wide[31:0];
            lost = (wide[63:32] != 32'd0);
            prod = 64'(signed'(x)) * (64'sd1 <<< s);
            sovf = (prod > 64'sd2147483647) || (prod < -64'sd2147483648);
            usum = {32'd0, sh} + {32'd0, b};
            ssum = 64'(signed'(sh)) + 64'(signed'(b));
            aovf = (ssum > 64'sd2147483647) || (ssum < -64'sd2147483648);
            m_res = usum[31:0];
            m_cc  = {m_res[31], m_res == 32'd0, sovf | aovf, lost | usum[32]};
            e.wr  = (d != 4'd0);
        end
        e.res = m_res;
        e.cc  = m_cc;
        return e;
    endfunction

    // Driver: apply one cycle of stimulus at the falling edge and push the expectation.
    task automatic issue(logic v, logic [15:0] ins, logic [31:0] dv,
                         logic [31:0] sv, string req);
        @(negedge clk);
        in_valid = v; instr = ins; dst_val = dv; src_val = sv;
        sb_q.push_back(model(v, ins, dv, sv, req));
    endtask

    function automatic logic [31:0] next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    // Monitor: 2 ns after each rising edge, compare the ports with the oldest expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (result !== e.res || wr_en !== e.wr || trap !== e.trp || flags !== e.cc) begin
                    n_bad++;
                    $display("FAIL %s: res=%h wr=%b trap=%b nzvc=%b, expected res=%h wr=%b trap=%b nzvc=%b",
                             e.req, result, wr_en, trap, flags, e.res, e.wr, e.trp, e.cc);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [6];
        pats = '{32'h0000_0001, 32'h8000_0001, 32'h7FFF_FFFF,
                 32'hFFFF_FFFF, 32'h0000_8000, 32'h4000_0000};
        repeat (3) @(posedge clk);
        #2;
        n_vec++; // R12 reset state
        if (result !== '0 || wr_en !== 1'b0 || trap !== 1'b0 || flags !== 4'd0) begin
            n_bad++;
            $display("FAIL R12: res=%h wr=%b trap=%b nzvc=%b, expected all zero",
                     result, wr_en, trap, flags);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R5 R6 R7: move-shift over every count encoding and edge operands.
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 6; p++)
                issue(1'b1, {4'b1011, 4'd3, 4'd5, 4'(c)}, next_rand(), pats[p], "R2 R1 R5 R6 R7 move-shift");
            issue(1'b1, {4'b1011, 4'd3, 4'd5, 4'(c)}, next_rand(), next_rand(), "R2 R1 move-shift random");
        end
        // R3 R5 R6: shift-add over every count encoding.
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 6; p++)
                issue(1'b1, {4'b1010, 4'd4, 4'd7, 4'(c)}, pats[p], pats[5-p], "R3 R1 R5 R6 R7 shift-add");
            issue(1'b1, {4'b1010, 4'd4, 4'd7, 4'(c)}, next_rand(), next_rand(), "R3 shift-add random");
            issue(1'b1, {4'b1010, 4'd4, 4'd7, 4'(c)}, 32'h0000_0001, 32'hFFFF_FFFF, "R5 add carry-out");
        end
        // R4: zero source index ignores src_val.
        for (int c = 0; c < 16; c++)
            issue(1'b1, {4'b1010, 4'd2, 4'd0, 4'(c)}, next_rand(), 32'hDEAD_BEEF, "R4 zero source");
        // R8: move-shift from register zero traps and leaves state alone.
        issue(1'b1, {4'b1011, 4'd3, 4'd5, 4'd1}, 32'd0, 32'hC000_0000, "R7 set flags");
        issue(1'b1, {4'b1011, 4'd3, 4'd0, 4'd2}, 32'h1, 32'h1, "R8 trap move-shift");
        // R9: shift-add into register zero traps.
        issue(1'b1, {4'b1010, 4'd0, 4'd6, 4'd3}, 32'h1, 32'h1, "R9 trap shift-add");
        // R10: bit test via move-shift with destination zero.
        issue(1'b1, {4'b1011, 4'd0, 4'd9, 4'd4}, 32'd0, 32'h0800_0000, "R10 bit test");
        issue(1'b1, {4'b1011, 4'd0, 4'd9, 4'd0}, 32'd0, 32'h0001_0000, "R10 bit test count 16");
        // R11: idle cycles and foreign opcodes change nothing.
        issue(1'b0, {4'b1011, 4'd3, 4'd5, 4'd1}, 32'h5, 32'h5, "R11 valid low");
        issue(1'b1, {4'b1001, 4'd3, 4'd5, 4'd1}, 32'h5, 32'h5, "R11 other opcode");
        issue(1'b1, {4'b1111, 4'd0, 4'd0, 4'd0}, 32'h5, 32'h5, "R11 other opcode");
        issue(1'b0, 16'h0000, 32'h0, 32'h0, "R11 idle");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule